// File: doc/BRIEF.md
# Completion Pointer Interrupt Controller

This block raises and retires transmit-completion interrupts for eight DMA channels. Each channel has one pointer register. When the DMA engine finishes a packet it writes the address of that packet's last descriptor into the channel's pointer. That write marks the channel pending, whatever the address is. The host services the channel and then writes back the address of the last descriptor it has handled. If that address equals the stored pointer, the pending bit clears. If it differs, the engine has finished more work than the host has seen, and the channel stays pending.

A small register bus gives the host its controls. It has a write-1-to-set and a write-1-to-clear port for the per-channel mask, readable raw and masked status, and a global output enable. An end-of-interrupt register drops the output line for one cycle, so an edge-triggered interrupt controller sees a fresh edge while work remains. The DMA side uses plain write strobes with no back-pressure, because the block accepts a pointer write in every cycle. Bus reads are combinational from the address. Bus writes take effect at the next rising clock edge.

Register addresses (4-bit): 0 = mask set, 1 = mask clear, 2 = raw status, 3 = masked status, 4 = end-of-interrupt, 5 = global enable (bit 0), 8+n = pointer of channel n.

Top module: `cpl_irq_ctrl`

## Requirements
- R1: After reset, all pointers, pending bits, mask bits and the enable are 0, and irq_out is 0.
- R2: A DMA pointer write to channel n sets raw status bit n at the next edge, whatever value is written. This includes zero and a value equal to the old pointer.
- R3: Reading address 8+n returns the value of the last DMA write to channel n. Host writes to that address never change it.
- R4: A host write to address 8+n whose data equals the stored pointer clears raw bit n at the next edge.
- R5: A host write to address 8+n whose data differs from the stored pointer leaves raw bit n set.
- R6: Writing to address 0 sets the mask bits where the data has a 1. Writing to address 1 clears the mask bits where the data has a 1. Zero bits change nothing.
- R7: Address 3 reads raw AND mask. Address 2 reads raw status whatever the mask holds.
- R8: irq_out is high only when the enable (address 5, bit 0) is 1 and at least one masked status bit is set.
- R9: A write of 2 to address 4 drives irq_out low for exactly the cycle after the write edge. After that cycle, irq_out follows R8 again. Writes of any other value to address 4 have no effect.
- R10: If a DMA write and a host write reach the same channel in the same cycle, the DMA write takes effect. The pointer takes the DMA value and the channel stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_wr_en | input | 1 | DMA pointer write strobe |
| dma_wr_chan | input | 3 | Channel of the DMA write |
| dma_wr_ptr | input | 32 | Last-descriptor address from the DMA side |
| bus_wr | input | 1 | Host register write strobe |
| bus_addr | input | 4 | Host register address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Completion interrupt line |

## Verification
A stuck or lost pending bit shows up on the raw status read one cycle after the pointer write that should have changed it. It also shows on irq_out in that same cycle, once the channel is unmasked and the enable is on. A wrong comparison between the host value and the stored pointer shows up in the same cycle, as a bit that clears on a stale address or one that will not clear on the exact one. A fault in the end-of-interrupt timing appears as an irq_out value that is wrong either in the single cycle after the EOI edge or in the cycle after that.

// File: rtl/cpl_irq_pkg.sv
package cpl_irq_pkg;
  localparam int unsigned REG_MASK_SET = 0;
  localparam int unsigned REG_MASK_CLR = 1;
  localparam int unsigned REG_RAW      = 2;
  localparam int unsigned REG_MASKED   = 3;
  localparam int unsigned REG_EOI      = 4;
  localparam int unsigned REG_GEN      = 5;
endpackage

// File: rtl/cpl_chan.sv
// One channel: stored completion pointer and its pending flag.
module cpl_chan #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_we,
  input  logic [PW-1:0] dma_ptr,
  input  logic          host_we,
  input  logic [PW-1:0] host_ptr,
  output logic [PW-1:0] ptr_q,
  output logic          pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else if (dma_we) begin
      // engine write always wins and always raises the channel
      ptr_q  <= dma_ptr;
      pend_q <= 1'b1;
    end else if (host_we && (host_ptr == ptr_q)) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpl_mask_reg.sv
// Per-channel mask with set/clear ports and the global output enable.
module cpl_mask_reg #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic           gen_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] mask_q,
  output logic           en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (set_we) mask_q <= mask_q | wbits;
      if (clr_we) mask_q <= mask_q & ~wbits;
      if (gen_we) en_q   <= wbits[0];
    end
  end
endmodule

// File: rtl/cpl_irq_out.sv
// Output line with a one-cycle drop after an end-of-interrupt write.
module cpl_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic eoi_we,
  input  logic req,
  output logic irq
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= eoi_we;
  end

  assign irq = req & ~hold_q;
endmodule

// File: rtl/cpl_irq_ctrl.sv
module cpl_irq_ctrl #(
  parameter int NCH      = 8,
  parameter int PW       = 32,
  parameter int AW       = 4,
  parameter int EOI_CODE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dma_wr_en,
  input  logic [$clog2(NCH)-1:0] dma_wr_chan,
  input  logic [PW-1:0]          dma_wr_ptr,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [PW-1:0]          bus_wdata,
  output logic [PW-1:0]          bus_rdata,
  output logic                   irq_out
);
  import cpl_irq_pkg::*;

  localparam int CHW = $clog2(NCH);

  logic [PW-1:0]  ptr_arr [NCH];
  logic [NCH-1:0] raw_q;
  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] masked;
  logic           en_q;
  logic           is_ptr;
  logic [CHW-1:0] hch;
  logic           host_ptr_we;
  logic           eoi_we;

  // pointer window: the upper address bits read as 1, the low bits pick the channel
  assign is_ptr      = (bus_addr[AW-1:CHW] == (AW-CHW)'(1));
  assign hch         = bus_addr[CHW-1:0];
  assign host_ptr_we = bus_wr && is_ptr;
  assign eoi_we      = bus_wr && (bus_addr == AW'(REG_EOI)) &&
                       (bus_wdata == PW'(EOI_CODE));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cpl_chan #(.PW(PW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .dma_we   (dma_wr_en && (dma_wr_chan == CHW'(g))),
      .dma_ptr  (dma_wr_ptr),
      .host_we  (host_ptr_we && (hch == CHW'(g))),
      .host_ptr (bus_wdata),
      .ptr_q    (ptr_arr[g]),
      .pend_q   (raw_q[g])
    );
  end

  cpl_mask_reg #(.NCH(NCH)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (bus_wr && (bus_addr == AW'(REG_MASK_SET))),
    .clr_we (bus_wr && (bus_addr == AW'(REG_MASK_CLR))),
    .gen_we (bus_wr && (bus_addr == AW'(REG_GEN))),
    .wbits  (bus_wdata[NCH-1:0]),
    .mask_q (mask_q),
    .en_q   (en_q)
  );

  assign masked = raw_q & mask_q;

  cpl_irq_out u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .eoi_we (eoi_we),
    .req    (en_q && (|masked)),
    .irq    (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (is_ptr) begin
      bus_rdata = ptr_arr[hch];
    end else begin
      case (bus_addr)
        AW'(REG_MASK_SET), AW'(REG_MASK_CLR): bus_rdata = PW'(mask_q);
        AW'(REG_RAW):    bus_rdata = PW'(raw_q);
        AW'(REG_MASKED): bus_rdata = PW'(masked);
        AW'(REG_GEN):    bus_rdata = PW'(en_q);
        default:         bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cpl_irq_chk.sv
module cpl_irq_chk #(
  parameter int NCH      = 8,
  parameter int PW       = 32,
  parameter int AW       = 4,
  parameter int EOI_CODE = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dma_wr_en,
  input logic [$clog2(NCH)-1:0] dma_wr_chan,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [PW-1:0]          bus_wdata,
  input logic [PW-1:0]          bus_rdata,
  input logic                   irq_out,
  input logic [NCH-1:0]         raw_q,
  input logic [NCH-1:0]         mask_q,
  input logic                   en_q
);
  localparam int CHW = $clog2(NCH);

  logic           wr_ptr;
  logic [CHW-1:0] hch;
  assign wr_ptr = bus_wr && (bus_addr[AW-1:CHW] == (AW-CHW)'(1));
  assign hch    = bus_addr[CHW-1:0];

  AST_DMA_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_en |=> raw_q[$past(dma_wr_chan)]);  // R2

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr && (bus_wdata == bus_rdata) && !(dma_wr_en && (dma_wr_chan == hch)))
      |=> !raw_q[$past(hch)]);  // R4

  AST_MISMATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr && (bus_wdata != bus_rdata) && raw_q[hch]) |=> raw_q[$past(hch)]);  // R5

  AST_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr && dma_wr_en && (dma_wr_chan == hch)) |=> raw_q[$past(hch)]);  // R10

  AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == AW'(0)))
      |=> ((mask_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));  // R6

  AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en_q && (|(raw_q & mask_q))));  // R8

  AST_EOI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == AW'(4)) && (bus_wdata == PW'(EOI_CODE))) |=> !irq_out);  // R9
endmodule

bind cpl_irq_ctrl cpl_irq_chk #(.NCH(NCH), .PW(PW), .AW(AW), .EOI_CODE(EOI_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dma_wr_en   (dma_wr_en),
  .dma_wr_chan (dma_wr_chan),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_out     (irq_out),
  .raw_q       (raw_q),
  .mask_q      (mask_q),
  .en_q        (en_q)
);

// File: tb/sim_cpl_irq_ctrl.sv
module sim_cpl_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_wr_en = 1'b0;
  logic [2:0]  dma_wr_chan = '0;
  logic [31:0] dma_wr_ptr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_ptr [8];

  always #10 clk = ~clk;  // 50 MHz

  cpl_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dma_wr_en(dma_wr_en), .dma_wr_chan(dma_wr_chan),
    .dma_wr_ptr(dma_wr_ptr), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {op[44:43] 0=dma 1=host, chan[42:40], value[39:8], expected raw[7:0]}
  localparam logic [44:0] VEC [12] = '{
    {2'd0, 3'd0, 32'h0000_0100, 8'h01},
    {2'd0, 3'd3, 32'h0000_0340, 8'h09},
    {2'd1, 3'd0, 32'h0000_00FC, 8'h09},
    {2'd1, 3'd0, 32'h0000_0100, 8'h08},
    {2'd1, 3'd3, 32'h0000_0340, 8'h00},
    {2'd0, 3'd7, 32'h0000_0000, 8'h80},
    {2'd1, 3'd7, 32'h0000_0000, 8'h00},
    {2'd0, 3'd5, 32'h0000_AAAA, 8'h20},
    {2'd0, 3'd5, 32'h0000_BBBB, 8'h20},
    {2'd1, 3'd5, 32'h0000_AAAA, 8'h20},
    {2'd1, 3'd5, 32'h0000_BBBB, 8'h00},
    {2'd1, 3'd2, 32'h0000_0000, 8'h00}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic dma_wr(logic [2:0] ch, logic [31:0] v);
    dma_wr_en = 1'b1; dma_wr_chan = ch; dma_wr_ptr = v;
    @(negedge clk);
    dma_wr_en = 1'b0;
  endtask

  task automatic host_wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 8; i++) model_ptr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd2, d); check("R1 raw", d, 32'h0);
    rd(4'd0, d); check("R1 mask", d, 32'h0);
    rd(4'd5, d); check("R1 enable", d, 32'h0);
    rd(4'd8, d); check("R1 ptr0", d, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // vector walk: pending set (R2), match clear (R4), mismatch hold (R5), pointer (R3)
    for (int i = 0; i < 12; i++) begin
      logic [2:0]  ch;
      logic [31:0] v;
      ch = VEC[i][42:40];
      v  = VEC[i][39:8];
      if (VEC[i][44:43] == 2'd0) begin
        dma_wr(ch, v);
        model_ptr[ch] = v;
      end else begin
        host_wr(4'd8 + {1'b0, ch}, v);
      end
      rd(4'd2, d);
      check((VEC[i][44:43] == 2'd0) ? "R2 raw after dma" :
            ((v == model_ptr[ch]) ? "R4 raw after match" : "R5 raw after mismatch"),
            d, {24'h0, VEC[i][7:0]});
      rd(4'd8 + {1'b0, ch}, d);
      check("R3 pointer readback", d, model_ptr[ch]);
    end

    // R6 mask set/clear
    host_wr(4'd0, 32'h05); rd(4'd0, d); check("R6 mask set", d, 32'h05);
    host_wr(4'd0, 32'h00); rd(4'd0, d); check("R6 zero set no effect", d, 32'h05);
    host_wr(4'd1, 32'h04); rd(4'd1, d); check("R6 mask clear", d, 32'h01);
    host_wr(4'd1, 32'h00); rd(4'd0, d); check("R6 zero clear no effect", d, 32'h01);

    // R7 masked vs raw
    dma_wr(3'd0, 32'h1000); model_ptr[0] = 32'h1000;
    dma_wr(3'd2, 32'h2000); model_ptr[2] = 32'h2000;
    rd(4'd2, d); check("R7 raw ignores mask", d, 32'h05);
    rd(4'd3, d); check("R7 masked", d, 32'h01);

    // R8 enable gating
    check("R8 irq low while disabled", {31'b0, irq_out}, 32'h0);
    host_wr(4'd5, 32'h1);
    #1 check("R8 irq high when enabled", {31'b0, irq_out}, 32'h1);

    // R9 EOI
    host_wr(4'd4, 32'h3);
    #1 check("R9 other value no gap", {31'b0, irq_out}, 32'h1);
    host_wr(4'd4, 32'h2);
    #1 check("R9 gap cycle", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    #1 check("R9 reassert", {31'b0, irq_out}, 32'h1);

    // R10 collision on channel 1: host value equals old pointer (0)
    dma_wr_en = 1'b1; dma_wr_chan = 3'd1; dma_wr_ptr = 32'h500;
    bus_wr = 1'b1; bus_addr = 4'd9; bus_wdata = 32'h0;
    @(negedge clk);
    dma_wr_en = 1'b0; bus_wr = 1'b0;
    rd(4'd2, d); check("R10 pending kept", d & 32'h2, 32'h2);
    rd(4'd9, d); check("R10 pointer from dma", d, 32'h500);

    // R8 masking everything drops the line while raw stays set
    host_wr(4'd1, 32'hFF);
    #1 check("R8 irq low when all masked", {31'b0, irq_out}, 32'h0);
    rd(4'd2, d); check("R8 raw unchanged", d, 32'h07);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule